// File: doc/BRIEF.md
# Systolic Matrix-Multiply Wavefront Sequencer

This block runs a single matrix product C = A × B on an external N×N weight-stationary systolic array. It takes both operand matrices and a start pulse, and stores the operands when it accepts the start. It then steps a phase counter through exactly 3N cycles.

In the first phase it presents the B matrix as weights, with a one-cycle valid strobe. In the following phases it feeds A into the array rows, with each row one cycle later than the row above it. It does not store this timing as a table of events. Each action fires when the phase counter equals a value computed from the row and column indices and N. That value includes the row skew and the registered partial-sum delay down each column.

The block samples the bottom output of each array column at the cycle when a given C element arrives there, and stores it. When the last element has been stored, the block pulses done and returns to idle. The assembled C matrix stays on the outputs until a later operation overwrites it.

Top module: `systolic_wavefront_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, the outputs are as follows: done_o and weight_valid_o are 0, row_data_o is all zero, and c_o is all zero.
- R2: A start_i seen high at a clock edge while idle begins an operation. In the cycle after that edge (phase 0), weight_valid_o is 1 and weight_o equals the B value sampled at that edge. Matrices are flattened row-major: element (i,j) sits at bits starting at (i*N+j)*DATA_W. weight_valid_o is 0 in every other cycle.
- R3: In phase t, the row_data_o slice for row k (bits starting at k*DATA_W) carries A[t-1-k][k] when 0 ≤ t-1-k < N, and zero otherwise. Row data is also zero whenever the block is idle.
- R4: Element C[i][j] is taken from column j of col_sum_i (bits starting at j*ACC_W) at the end of phase i+j+N+1. It is stored in c_o at bits starting at (i*N+j)*ACC_W.
- R5: done_o is a one-cycle pulse. It is high in the cycle after phase 3N-1, which is 3N clock edges after the edge that accepted the start.
- R6: A start pulse during an active operation is ignored. Changes to a_i or b_i after the start edge have no effect on the row data, the weights or the result of that operation.
- R7: After done, c_o holds its value while the block is idle, whatever col_sum_i and the operand inputs do.
- R8: After done, the block is idle. It accepts a new start in any later cycle, including the done cycle itself, and runs a full operation again.
- R9: With A = [[1,2,3],[4,5,6],[7,8,9]] and B = [[2,0,1],[0,2,0],[1,0,2]] and N = 3, c_o ends as [[5,4,7],[14,10,16],[23,16,25]].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| a_i | input | N*N*DATA_W | Activation matrix A, row-major |
| b_i | input | N*N*DATA_W | Weight matrix B, row-major |
| col_sum_i | input | N*ACC_W | Bottom partial-sum output of each array column |
| row_data_o | output | N*DATA_W | Activation injected into the left edge of each array row |
| weight_o | output | N*N*DATA_W | Weights for the array, row-major |
| weight_valid_o | output | 1 | Weight-load strobe, high in phase 0 only |
| c_o | output | N*N*ACC_W | Assembled result matrix, row-major |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start_i is synchronous to clk_i. They also assume that col_sum_i comes from a registered array whose partial sums advance exactly one row per cycle. They rely on a_i and b_i only at the start edge. The bench meets these assumptions as follows:
- It drives every input on the falling edge.
- It derives col_sum_i from a cycle-accurate array model, with weights latched on the valid strobe and a zero partial sum at the top.
- It changes the operands and pulses start in the middle of an operation, so that a design which fails to ignore them shows up at the ports.

// File: rtl/systolic_seq_pkg.sv
package systolic_seq_pkg;
  // phase on whose closing edge C[i][j] sits at the bottom of column j
  function automatic int cap_phase(int i, int j, int n);
    return i + j + n + 1;
  endfunction

  // first phase of row k's feed window
  function automatic int feed_phase(int i, int k);
    return 1 + i + k;
  endfunction

  function automatic int last_phase(int n);
    return 3 * n - 1;
  endfunction
endpackage

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr #(
  parameter int N    = 3,
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            active_o,
  output logic [PH_W-1:0] phase_o,
  output logic            accept_o,
  output logic            done_o
);
  import systolic_seq_pkg::*;
  localparam logic [PH_W-1:0] LAST = PH_W'(last_phase(N));

  logic            active_q, done_q;
  logic [PH_W-1:0] phase_q;

  assign accept_o = start_i & ~active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          phase_q  <= '0;
        end
      end else if (phase_q == LAST) begin
        active_q <= 1'b0;
        phase_q  <= '0;
        done_q   <= 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign done_o   = done_q;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && phase_q == LAST) |=> (done_o && !active_o));
  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i && phase_q != LAST) |=> (active_o && phase_o == $past(phase_q) + 1'b1));
endmodule

// File: rtl/seq_row_feed.sv
module seq_row_feed #(
  parameter int N      = 3,
  parameter int DATA_W = 8,
  parameter int PH_W   = 4
) (
  input  logic                   active_i,
  input  logic [PH_W-1:0]        phase_i,
  input  logic [N*N*DATA_W-1:0]  a_i,
  output logic [N*DATA_W-1:0]    row_o
);
  import systolic_seq_pkg::*;

  for (genvar k = 0; k < N; k++) begin : g_row
    logic [DATA_W-1:0] val;
    always_comb begin
      val = '0;
      for (int i = 0; i < N; i++) begin
        if (active_i && phase_i == PH_W'(feed_phase(i, k)))
          val = a_i[(i*N+k)*DATA_W +: DATA_W];
      end
    end
    assign row_o[k*DATA_W +: DATA_W] = val;
  end
endmodule

// File: rtl/seq_result_cap.sv
module seq_result_cap #(
  parameter int N     = 3,
  parameter int ACC_W = 20,
  parameter int PH_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic [PH_W-1:0]       phase_i,
  input  logic [N*ACC_W-1:0]    col_sum_i,
  output logic [N*N*ACC_W-1:0]  c_o
);
  import systolic_seq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_i
    for (genvar j = 0; j < N; j++) begin : g_j
      localparam logic [PH_W-1:0] CAP = PH_W'(cap_phase(i, j, N));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          c_o[(i*N+j)*ACC_W +: ACC_W] <= '0;
        else if (active_i && phase_i == CAP)
          c_o[(i*N+j)*ACC_W +: ACC_W] <= col_sum_i[j*ACC_W +: ACC_W];
      end
    end
  end

  assert_c_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(c_o));
endmodule

// File: rtl/systolic_wavefront_seq.sv
module systolic_wavefront_seq #(
  parameter int N      = 3,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N*N*DATA_W-1:0] a_i,
  input  logic [N*N*DATA_W-1:0] b_i,
  input  logic [N*ACC_W-1:0]    col_sum_i,
  output logic [N*DATA_W-1:0]   row_data_o,
  output logic [N*N*DATA_W-1:0] weight_o,
  output logic                  weight_valid_o,
  output logic [N*N*ACC_W-1:0]  c_o,
  output logic                  done_o
);
  import systolic_seq_pkg::*;
  localparam int PH_W = $clog2(last_phase(N) + 2);

  logic            active, accept;
  logic [PH_W-1:0] phase;
  logic [N*N*DATA_W-1:0] a_q, b_q;

  seq_phase_ctr #(.N(N), .PH_W(PH_W)) i_ctr (
    .clk_i, .rst_ni, .start_i,
    .active_o(active), .phase_o(phase), .accept_o(accept), .done_o
  );

  // operands frozen at the accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign weight_o       = b_q;
  assign weight_valid_o = active && (phase == '0);

  seq_row_feed #(.N(N), .DATA_W(DATA_W), .PH_W(PH_W)) i_feed (
    .active_i(active), .phase_i(phase), .a_i(a_q), .row_o(row_data_o)
  );

  seq_result_cap #(.N(N), .ACC_W(ACC_W), .PH_W(PH_W)) i_cap (
    .clk_i, .rst_ni, .active_i(active), .phase_i(phase),
    .col_sum_i, .c_o
  );

  assert_wvalid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    weight_valid_o |=> !weight_valid_o);
  assert_wvalid_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active) |=> weight_valid_o);
  assert_rows_quiet_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    weight_valid_o |-> row_data_o == '0);
  assert_no_done_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !weight_valid_o && row_data_o == '0);
endmodule

// File: tb/test_systolic_wavefront_seq.sv
module test_systolic_wavefront_seq;
  localparam int N = 3, W = 8, AW = 20;
  localparam int MW = N*N*W, CW = N*N*AW;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [MW-1:0] a_i = '0, b_i = '0, weight_o;
  logic [N*AW-1:0] col_sum_i;
  logic [N*W-1:0] row_data_o;
  logic weight_valid_o, done_o;
  logic [CW-1:0] c_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  systolic_wavefront_seq #(.N(N), .DATA_W(W), .ACC_W(AW)) i_systolic_wavefront_seq (.*);

  // cycle-accurate weight-stationary array model
  logic [W-1:0]  wq [N][N];
  logic [W-1:0]  dq [N][N];
  logic [AW-1:0] ps [N][N];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          wq[r][c] <= '0; dq[r][c] <= '0; ps[r][c] <= '0;
        end
    end else begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          if (weight_valid_o) wq[r][c] <= weight_o[(r*N+c)*W +: W];
          dq[r][c] <= (c == 0) ? row_data_o[r*W +: W] : dq[r][c-1];
          ps[r][c] <= ((r == 0) ? AW'(0) : ps[r-1][c])
                    + AW'((c == 0) ? row_data_o[r*W +: W] : dq[r][c-1]) * AW'(wq[r][c]);
        end
    end
  end
  always_comb
    for (int c = 0; c < N; c++) col_sum_i[c*AW +: AW] = ps[N-1][c];

  localparam logic [MW-1:0] EX_A = {8'd9,8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1};
  localparam logic [MW-1:0] EX_B = {8'd2,8'd0,8'd1,8'd0,8'd2,8'd0,8'd1,8'd0,8'd2};
  localparam logic [CW-1:0] EX_C = {20'd25,20'd16,20'd23,20'd16,20'd10,20'd14,20'd7,20'd4,20'd5};

  // stimulus table: A, B and the cycle at which to poke start/operands (-1 none)
  localparam int NV = 4;
  localparam logic [MW-1:0] VA [NV] = '{
    {8'd9,8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1},
    {MW{1'b1}},
    {8'd3,8'd0,8'd200,8'd17,8'd1,8'd0,8'd99,8'd5,8'd250},
    {8'd0,8'd0,8'd1,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}};
  localparam logic [MW-1:0] VB [NV] = '{
    {8'd1,8'd0,8'd0,8'd0,8'd1,8'd0,8'd0,8'd0,8'd1},
    {MW{1'b1}},
    {8'd7,8'd128,8'd0,8'd1,8'd2,8'd3,8'd255,8'd4,8'd11},
    {8'd5,8'd6,8'd7,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}};
  localparam int VPOKE [NV] = '{-1, 4, 2, -1};

  function automatic logic [CW-1:0] ref_mm(input logic [MW-1:0] a, input logic [MW-1:0] b);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [AW-1:0] s = '0;
        for (int k = 0; k < N; k++)
          s += AW'(a[(i*N+k)*W +: W]) * AW'(b[(k*N+j)*W +: W]);
        c[(i*N+j)*AW +: AW] = s;
      end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // entered at a falling edge; returns at the falling edge of the done cycle
  task automatic run_op(input logic [MW-1:0] a, input logic [MW-1:0] b, input int poke);
    logic [CW-1:0] exp = ref_mm(a, b);
    logic [W-1:0] er;
    a_i = a; b_i = b; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    for (int cyc = 0; cyc <= 3*N + 2; cyc++) begin
      chk(weight_valid_o == (cyc == 0), "R2 weight_valid", CW'(weight_valid_o), CW'(cyc == 0));
      if (cyc == 0) chk(weight_o == b, "R2 weight_o", CW'(weight_o), CW'(b));
      for (int k = 0; k < N; k++) begin
        er = (cyc >= 1 + k && cyc <= N + k) ? a[((cyc-1-k)*N+k)*W +: W] : '0;
        chk(row_data_o[k*W +: W] == er, (poke >= 0) ? "R6 row data after poke" : "R3 row data",
            CW'(row_data_o[k*W +: W]), CW'(er));
      end
      chk(done_o == (cyc == 3*N), "R5 done timing", CW'(done_o), CW'(cyc == 3*N));
      if (cyc == 3*N) break;
      if (cyc == 3*N + 2) chk(1'b0, "R5 done missing", '0, '1);
      if (cyc == poke) begin start_i = 1'b1; a_i = ~a; b_i = ~b; end
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(c_o == exp, (poke >= 0) ? "R6 result after poke" : "R4 result", c_o, exp);
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog", '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] held;
    #23;
    chk(done_o == 0 && weight_valid_o == 0, "R1 ctrl in reset", CW'({done_o, weight_valid_o}), '0);
    chk(row_data_o == '0 && c_o == '0, "R1 data in reset", c_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk(done_o == 0 && weight_valid_o == 0 && row_data_o == '0, "R1 idle after reset",
        CW'({done_o, weight_valid_o, row_data_o}), '0);

    run_op(EX_A, EX_B, -1);
    chk(c_o == EX_C, "R9 stated example", c_o, EX_C);

    // table: each op starts in the previous done cycle (R8 back-to-back)
    for (int v = 0; v < NV; v++) run_op(VA[v], VB[v], VPOKE[v]);

    // R7: idle hold against changing operands and column sums
    held = c_o;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk_i);
      a_i = MW'(n * 37); b_i = ~a_i;
      chk(c_o == held, "R7 c hold", c_o, held);
      chk(done_o == 0 && weight_valid_o == 0 && row_data_o == '0, "R8 idle quiet",
          CW'({done_o, weight_valid_o, row_data_o}), '0);
    end

    // R8: fresh start after idle time
    run_op(VA[2], VB[0], -1);
    @(negedge clk_i);
    chk(done_o == 0, "R5 done single pulse", CW'(done_o), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule